// File: doc/BRIEF.md
# Named Warp Barrier Unit

This block tracks barrier synchronisation for the warps of one compute core. Each thread block (CTA) can use several numbered barriers. A warp that reaches a synchronising barrier is held: its bit in the `blocked` mask gates instruction fetch until the barrier opens. A warp that only announces arrival is counted but keeps running. A barrier opens in one of two ways. In all-warp mode, it opens once every active warp of the CTA has reached it. In counted mode, it opens once the arrived warps, multiplied by the warp size, equal an expected thread count.

When a barrier opens, the block emits a one-cycle release pulse. The pulse carries the CTA, the barrier number and the mask of the released warps. If the barrier was a reduction barrier, the block also raises a broadcast request on a valid/ready output; the arithmetic itself is done elsewhere. Launch events bind a warp to a CTA. An exit event retires a warp and then sweeps every barrier of its CTA, so that all-warp barriers that were waiting only on that warp can open.

Barrier events and exit events arrive on valid/ready inputs. Back-pressure works as follows:
- `bar_ready` falls while an exit sweep runs, and while a broadcast request is waiting for `red_ready`.
- `exit_ready` additionally falls whenever `bar_valid` is high, so barrier events win over exits.
- A broadcast request holds its payload stable until it is taken.
- Launch is a plain strobe.

Top module: `named_barrier_unit`

## Requirements
- R1: After reset, `blocked` is zero and `rel_valid`, `red_valid` and `error` are low. `bar_ready` and `exit_ready` are high, and no warp is active.
- R2: An accepted, error-free event of kind sync (2'd0) or reduce (2'd1) sets the warp's `blocked` bit on the next cycle, unless that same event opens the barrier. Kind arrive (2'd2) never sets it.
- R3: With `bar_count` equal to zero (all-warp mode), an event opens its barrier when the CTA's warps recorded on that barrier id, including the new one, equal the CTA's active warps. The release pulse appears one cycle after the event and carries `rel_cta`, `rel_id` and `rel_warps`.
- R4: With a non-zero `bar_count` (counted mode), the barrier opens when the number of recorded warps of the CTA times WARP_SIZE equals `bar_count`.
- R5: A release clears the released warps from `blocked` and from that barrier's record in the same cycle as the pulse, so the next use of the barrier starts empty.
- R6: Barriers are evaluated per CTA. Warps of another CTA that are recorded on the same barrier id neither open it nor appear in its release mask.
- R7: When a barrier opens and its last event, or any recorded event, was of kind reduce, `red_valid` rises together with the release pulse, with matching CTA, id and warp mask. The request and its payload hold until `red_ready`. While it is held, `bar_ready` and `exit_ready` are low.
- R8: An accepted exit clears the warp's active and blocked bits and removes it from every barrier. A sweep then evaluates barrier id b of the warp's CTA, b+1 cycles after acceptance, and opens every non-empty all-warp barrier that is now satisfied. Both ready outputs stay low during the NUM_BARS-cycle sweep.
- R9: An event is rejected when any of the following holds:
  - its id is at least NUM_BARS;
  - its kind is 2'd3;
  - its warp is not active;
  - its warp belongs to another CTA.

  A rejected event raises `error` for one cycle and changes no state.
- R10: A launch strobe makes the warp active and binds it to `launch_cta` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch strobe |
| launch_warp | input | 5 | Warp being launched |
| launch_cta | input | 3 | CTA the warp joins |
| exit_valid | input | 1 | Exit event valid |
| exit_ready | output | 1 | Exit event accepted |
| exit_warp | input | 5 | Exiting warp |
| bar_valid | input | 1 | Barrier event valid |
| bar_ready | output | 1 | Barrier event accepted |
| bar_cta | input | 3 | CTA named by the event |
| bar_warp | input | 5 | Warp issuing the event |
| bar_id | input | 5 | Barrier number (out-of-range values are rejected) |
| bar_kind | input | 2 | 0 sync, 1 reduce, 2 arrive |
| bar_count | input | 11 | Expected threads, 0 for all-warp mode |
| blocked | output | 32 | Warps held at a barrier |
| rel_valid | output | 1 | One-cycle release pulse |
| rel_cta | output | 3 | CTA of the release |
| rel_id | output | 4 | Barrier number released |
| rel_warps | output | 32 | Warps released |
| red_valid | output | 1 | Reduction broadcast request valid |
| red_ready | input | 1 | Broadcast request taken |
| red_cta | output | 3 | CTA of the broadcast |
| red_id | output | 4 | Barrier number of the broadcast |
| red_warps | output | 32 | Warps taking part in the broadcast |
| error | output | 1 | Rejected event pulse |

## Verification
Event results are due one cycle after acceptance:
- the blocked bit;
- the release pulse;
- the broadcast request;
- the error pulse.

The bench drives each event on a falling edge and samples one time unit after the next rising edge. An exit's sweep results come later: barrier id b is due b+1 cycles after the accepting edge, so the bench counts exactly that many edges, checks that no pulse came early, and checks that the ready outputs recover NUM_BARS cycles after the exit. A held broadcast is sampled over several stalled cycles before `red_ready` is raised, and it must drop one edge later.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
  typedef enum logic [1:0] {
    BK_SYNC   = 2'd0,
    BK_REDUCE = 2'd1,
    BK_ARRIVE = 2'd2,
    BK_BAD    = 2'd3
  } bar_kind_e;
endpackage

// File: rtl/nwb_cta_select.sv
module nwb_cta_select #(
  parameter int NUM_WARPS = 32,
  parameter int CTA_W     = 3
) (
  input  logic [NUM_WARPS-1:0]       member,
  input  logic [NUM_WARPS*CTA_W-1:0] warp_cta_flat,
  input  logic [CTA_W-1:0]           cta,
  output logic [NUM_WARPS-1:0]       cta_set
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    assign cta_set[w] = member[w] && (warp_cta_flat[w*CTA_W +: CTA_W] == cta);
  end
endmodule

// File: rtl/nwb_release_eval.sv
module nwb_release_eval #(
  parameter int NUM_WARPS = 32,
  parameter int WARP_SIZE = 32,
  parameter int CNT_W     = 11
) (
  input  logic [NUM_WARPS-1:0] at_mask,
  input  logic [NUM_WARPS-1:0] act_mask,
  input  logic [CNT_W-1:0]     count,
  output logic                 fire
);
  logic [31:0] ones;

  always_comb begin
    ones = '0;
    for (int w = 0; w < NUM_WARPS; w++) ones = ones + 32'(at_mask[w]);
  end

  always_comb begin
    if (count == '0) fire = (at_mask != '0) && (at_mask == act_mask);
    else             fire = ((ones * 32'(WARP_SIZE)) == 32'(count));
  end
endmodule

// File: rtl/named_barrier_unit.sv
module named_barrier_unit #(
  parameter int NUM_WARPS = 32,
  parameter int NUM_BARS  = 16,
  parameter int NUM_CTAS  = 8,
  parameter int WARP_SIZE = 32,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int CTA_W = $clog2(NUM_CTAS),
  localparam int BIX_W = $clog2(NUM_BARS),
  localparam int BID_W = BIX_W + 1,
  localparam int CNT_W = $clog2(NUM_WARPS*WARP_SIZE+1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  input  logic [WID_W-1:0]     launch_warp,
  input  logic [CTA_W-1:0]     launch_cta,
  input  logic                 exit_valid,
  output logic                 exit_ready,
  input  logic [WID_W-1:0]     exit_warp,
  input  logic                 bar_valid,
  output logic                 bar_ready,
  input  logic [CTA_W-1:0]     bar_cta,
  input  logic [WID_W-1:0]     bar_warp,
  input  logic [BID_W-1:0]     bar_id,
  input  logic [1:0]           bar_kind,
  input  logic [CNT_W-1:0]     bar_count,
  output logic [NUM_WARPS-1:0] blocked,
  output logic                 rel_valid,
  output logic [CTA_W-1:0]     rel_cta,
  output logic [BIX_W-1:0]     rel_id,
  output logic [NUM_WARPS-1:0] rel_warps,
  output logic                 red_valid,
  input  logic                 red_ready,
  output logic [CTA_W-1:0]     red_cta,
  output logic [BIX_W-1:0]     red_id,
  output logic [NUM_WARPS-1:0] red_warps,
  output logic                 error
);
  import nwb_pkg::*;

  localparam int MAX_WARPS = 64;
  localparam int MAX_BARS  = 32;

  if (NUM_WARPS > MAX_WARPS || NUM_BARS > MAX_BARS) begin : g_cfg_reject
    $error("named_barrier_unit: configuration exceeds hardware maxima");
  end

  // state
  logic [NUM_WARPS-1:0] active, member;
  logic [CTA_W-1:0]     warp_cta   [NUM_WARPS];
  logic [NUM_WARPS-1:0] bar_mask   [NUM_BARS];
  logic [NUM_BARS-1:0]  counted    [NUM_CTAS];
  logic [NUM_BARS-1:0]  red_flag   [NUM_CTAS];
  logic                 sweeping;
  logic [BIX_W-1:0]     sweep_idx;
  logic [CTA_W-1:0]     sweep_cta;

  logic [NUM_WARPS*CTA_W-1:0] warp_cta_flat;
  always_comb
    for (int w = 0; w < NUM_WARPS; w++) warp_cta_flat[w*CTA_W +: CTA_W] = warp_cta[w];

  // handshake
  logic red_stall, ev_fire, ex_go;
  assign red_stall  = red_valid && !red_ready;
  assign bar_ready  = !sweeping && !red_stall;
  assign exit_ready = !sweeping && !red_stall && !bar_valid;
  assign ev_fire    = bar_valid && bar_ready;
  assign ex_go      = exit_valid && exit_ready;

  // event path
  logic [BIX_W-1:0]     bix;
  logic                 ev_ok, ev_err, ev_go, ev_rel, ev_red;
  logic [NUM_WARPS-1:0] ev_onehot, ev_cta_set, ev_at, ev_act;

  assign bix       = bar_id[BIX_W-1:0];
  assign ev_onehot = NUM_WARPS'(1) << bar_warp;
  assign ev_ok     = (32'(bar_id) < NUM_BARS) && (bar_kind != BK_BAD) &&
                     member[bar_warp] && active[bar_warp] && (warp_cta[bar_warp] == bar_cta);
  assign ev_err    = ev_fire && !ev_ok;
  assign ev_go     = ev_fire && ev_ok;
  assign ev_at     = (bar_mask[bix] | ev_onehot) & ev_cta_set;
  assign ev_act    = ev_cta_set & active;
  assign ev_red    = (bar_kind == BK_REDUCE) || red_flag[bar_cta][bix];

  nwb_cta_select #(.NUM_WARPS(NUM_WARPS), .CTA_W(CTA_W)) u_ev_sel (
    .member(member), .warp_cta_flat(warp_cta_flat), .cta(bar_cta), .cta_set(ev_cta_set));

  nwb_release_eval #(.NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE), .CNT_W(CNT_W)) u_ev_eval (
    .at_mask(ev_at), .act_mask(ev_act), .count(bar_count), .fire(ev_rel));

  // sweep path (all-warp barriers only)
  logic [NUM_WARPS-1:0] sw_cta_set, sw_at, sw_act;
  logic                 sw_fire, sw_step, sw_rel;

  assign sw_at   = bar_mask[sweep_idx] & sw_cta_set;
  assign sw_act  = sw_cta_set & active;
  assign sw_step = sweeping && !red_stall;
  assign sw_rel  = sw_step && !counted[sweep_cta][sweep_idx] && sw_fire;

  nwb_cta_select #(.NUM_WARPS(NUM_WARPS), .CTA_W(CTA_W)) u_sw_sel (
    .member(member), .warp_cta_flat(warp_cta_flat), .cta(sweep_cta), .cta_set(sw_cta_set));

  nwb_release_eval #(.NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE), .CNT_W(CNT_W)) u_sw_eval (
    .at_mask(sw_at), .act_mask(sw_act), .count('0), .fire(sw_fire));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= '0;
      member    <= '0;
      blocked   <= '0;
      sweeping  <= 1'b0;
      sweep_idx <= '0;
      sweep_cta <= '0;
      rel_valid <= 1'b0;
      rel_cta   <= '0;
      rel_id    <= '0;
      rel_warps <= '0;
      red_valid <= 1'b0;
      red_cta   <= '0;
      red_id    <= '0;
      red_warps <= '0;
      error     <= 1'b0;
      for (int w = 0; w < NUM_WARPS; w++) warp_cta[w] <= '0;
      for (int b = 0; b < NUM_BARS; b++)  bar_mask[b] <= '0;
      for (int c = 0; c < NUM_CTAS; c++) begin
        counted[c]  <= '0;
        red_flag[c] <= '0;
      end
    end else begin
      rel_valid <= 1'b0;
      error     <= ev_err;
      if (red_valid && red_ready) red_valid <= 1'b0;

      if (launch_valid) begin
        active[launch_warp]   <= 1'b1;
        member[launch_warp]   <= 1'b1;
        warp_cta[launch_warp] <= launch_cta;
      end

      if (ev_go) begin
        if (ev_rel) begin
          bar_mask[bix]          <= bar_mask[bix] & ~ev_at;
          blocked                <= blocked & ~ev_at;
          counted[bar_cta][bix]  <= 1'b0;
          red_flag[bar_cta][bix] <= 1'b0;
          rel_valid <= 1'b1;
          rel_cta   <= bar_cta;
          rel_id    <= bix;
          rel_warps <= ev_at;
          if (ev_red) begin
            red_valid <= 1'b1;
            red_cta   <= bar_cta;
            red_id    <= bix;
            red_warps <= ev_at;
          end
        end else begin
          bar_mask[bix]         <= bar_mask[bix] | ev_onehot;
          counted[bar_cta][bix] <= (bar_count != '0);
          if (bar_kind != BK_ARRIVE) blocked[bar_warp] <= 1'b1;
          if (bar_kind == BK_REDUCE) red_flag[bar_cta][bix] <= 1'b1;
        end
      end

      if (ex_go) begin
        active[exit_warp]  <= 1'b0;
        blocked[exit_warp] <= 1'b0;
        for (int b = 0; b < NUM_BARS; b++) bar_mask[b][exit_warp] <= 1'b0;
        sweeping  <= 1'b1;
        sweep_idx <= '0;
        sweep_cta <= warp_cta[exit_warp];
      end

      if (sw_step) begin
        if (sw_rel) begin
          bar_mask[sweep_idx]            <= bar_mask[sweep_idx] & ~sw_at;
          blocked                        <= blocked & ~sw_at;
          red_flag[sweep_cta][sweep_idx] <= 1'b0;
          rel_valid <= 1'b1;
          rel_cta   <= sweep_cta;
          rel_id    <= sweep_idx;
          rel_warps <= sw_at;
          if (red_flag[sweep_cta][sweep_idx]) begin
            red_valid <= 1'b1;
            red_cta   <= sweep_cta;
            red_id    <= sweep_idx;
            red_warps <= sw_at;
          end
        end
        sweep_idx <= sweep_idx + 1'b1;
        if (sweep_idx == BIX_W'(NUM_BARS-1)) sweeping <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/named_barrier_unit_chk.sv
module named_barrier_unit_chk #(
  parameter int NUM_WARPS = 32,
  parameter int NUM_BARS  = 16,
  parameter int NUM_CTAS  = 8,
  parameter int WARP_SIZE = 32,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int CTA_W = $clog2(NUM_CTAS),
  localparam int BIX_W = $clog2(NUM_BARS),
  localparam int BID_W = BIX_W + 1,
  localparam int CNT_W = $clog2(NUM_WARPS*WARP_SIZE+1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 launch_valid,
  input logic [WID_W-1:0]     launch_warp,
  input logic [CTA_W-1:0]     launch_cta,
  input logic                 exit_valid,
  input logic                 exit_ready,
  input logic [WID_W-1:0]     exit_warp,
  input logic                 bar_valid,
  input logic                 bar_ready,
  input logic [CTA_W-1:0]     bar_cta,
  input logic [WID_W-1:0]     bar_warp,
  input logic [BID_W-1:0]     bar_id,
  input logic [1:0]           bar_kind,
  input logic [CNT_W-1:0]     bar_count,
  input logic [NUM_WARPS-1:0] blocked,
  input logic                 rel_valid,
  input logic [CTA_W-1:0]     rel_cta,
  input logic [BIX_W-1:0]     rel_id,
  input logic [NUM_WARPS-1:0] rel_warps,
  input logic                 red_valid,
  input logic                 red_ready,
  input logic [CTA_W-1:0]     red_cta,
  input logic [BIX_W-1:0]     red_id,
  input logic [NUM_WARPS-1:0] red_warps,
  input logic                 error
);
  AST_ARRIVE_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    bar_valid && bar_ready && bar_kind == 2'd2 && !blocked[bar_warp] |=> !blocked[$past(bar_warp)]); // R2

  AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bar_valid && bar_ready && bar_kind == 2'd0 |=>
      blocked[$past(bar_warp)] || error || (rel_valid && rel_warps[$past(bar_warp)])); // R2

  AST_RELEASE_UNBLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (blocked & rel_warps) == '0); // R5

  AST_BCAST_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(red_valid) |-> rel_valid && rel_warps == red_warps && rel_id == red_id); // R7

  AST_BCAST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    red_valid && !red_ready |=> red_valid && $stable(red_warps) && $stable(red_id) && $stable(red_cta)); // R7

  AST_BCAST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    red_valid && !red_ready |-> !bar_ready && !exit_ready); // R7

  AST_ERROR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !rel_valid); // R9

  AST_EXIT_UNBLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid && exit_ready |=> !blocked[$past(exit_warp)] && !bar_ready); // R8
endmodule

bind named_barrier_unit named_barrier_unit_chk #(
  .NUM_WARPS(NUM_WARPS), .NUM_BARS(NUM_BARS), .NUM_CTAS(NUM_CTAS), .WARP_SIZE(WARP_SIZE)
) u_chk (.*);

// File: tb/named_barrier_unit_test.sv
`timescale 1ns/1ps
module named_barrier_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_valid = 1'b0;
  logic [4:0]  launch_warp = '0;
  logic [2:0]  launch_cta = '0;
  logic        exit_valid = 1'b0;
  logic        exit_ready;
  logic [4:0]  exit_warp = '0;
  logic        bar_valid = 1'b0;
  logic        bar_ready;
  logic [2:0]  bar_cta = '0;
  logic [4:0]  bar_warp = '0;
  logic [4:0]  bar_id = '0;
  logic [1:0]  bar_kind = '0;
  logic [10:0] bar_count = '0;
  logic [31:0] blocked;
  logic        rel_valid;
  logic [2:0]  rel_cta;
  logic [3:0]  rel_id;
  logic [31:0] rel_warps;
  logic        red_valid;
  logic        red_ready = 1'b1;
  logic [2:0]  red_cta;
  logic [3:0]  red_id;
  logic [31:0] red_warps;
  logic        error;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  named_barrier_unit uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic launch(input int w, input int c);
    @(negedge clk);
    launch_valid = 1'b1; launch_warp = 5'(w); launch_cta = 3'(c);
    step();
    launch_valid = 1'b0;
  endtask

  task automatic ev(input int c, input int w, input int id, input int kind, input int cnt);
    @(negedge clk);
    bar_valid = 1'b1; bar_cta = 3'(c); bar_warp = 5'(w);
    bar_id = 5'(id); bar_kind = 2'(kind); bar_count = 11'(cnt);
    step();
    bar_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 blocked",    64'(blocked), 64'h0);
    check("R1 rel_valid",  64'(rel_valid), 64'h0);
    check("R1 red_valid",  64'(red_valid), 64'h0);
    check("R1 error",      64'(error), 64'h0);
    check("R1 readies",    64'({bar_ready, exit_ready}), 64'h3);
  endtask

  task automatic t_sync_all();
    ev(0, 0, 3, 0, 0); check("R2 sync blocks", 64'(blocked), 64'h1);
    ev(0, 1, 3, 0, 0); check("R2 second block", 64'(blocked), 64'h3);
    ev(0, 2, 3, 0, 0); check("R3 no early release", 64'({rel_valid, blocked}), 64'h7);
    ev(0, 3, 3, 2, 0);
    check("R3 release pulse", 64'({rel_valid, rel_cta, rel_id}), {57'h0, 1'b1, 3'd0, 4'd3});
    check("R3 release mask", 64'(rel_warps), 64'hF);
    check("R5 blocked cleared", 64'(blocked), 64'h0);
    step(); check("R3 pulse one cycle", 64'(rel_valid), 64'h0);
  endtask

  task automatic t_arrive();
    ev(0, 0, 5, 2, 0); check("R2 arrive no block", 64'({rel_valid, blocked}), 64'h0);
    ev(0, 1, 5, 0, 0);
    ev(0, 2, 5, 0, 0); check("R2 mixed block", 64'(blocked), 64'h6);
    ev(0, 3, 5, 0, 0);
    check("R3 arrive counted", 64'({rel_valid, rel_warps}), {31'h0, 1'b1, 32'hF});
    check("R5 clear after arrive set", 64'(blocked), 64'h0);
  endtask

  task automatic t_counted();
    ev(1, 4, 1, 0, 64); check("R4 one of two", 64'({rel_valid, blocked}), 64'h10);
    ev(0, 0, 1, 0, 64); check("R6 other cta apart", 64'({rel_valid, blocked}), 64'h11);
    ev(1, 5, 1, 0, 64);
    check("R4 count met", 64'({rel_valid, rel_cta, rel_id}), {57'h0, 1'b1, 3'd1, 4'd1});
    check("R6 mask only cta1", 64'(rel_warps), 64'h30);
    check("R6 cta0 still held", 64'(blocked), 64'h01);
    ev(0, 1, 1, 0, 64);
    check("R4 cta0 count met", 64'({rel_valid, rel_cta, rel_warps}), {28'h0, 1'b1, 3'd0, 32'h3});
  endtask

  task automatic t_reduce();
    @(negedge clk); red_ready = 1'b0;
    ev(1, 4, 2, 1, 0); check("R7 no early bcast", 64'({red_valid, blocked}), 64'h10);
    ev(1, 5, 2, 1, 0);
    check("R7 bcast raised", 64'({red_valid, rel_valid, red_cta, red_id}), {54'h0, 2'b11, 3'd1, 4'd2});
    check("R7 bcast mask", 64'(red_warps), 64'h30);
    check("R7 back-pressure", 64'({bar_ready, exit_ready}), 64'h0);
    step(); step();
    check("R7 bcast held", 64'({red_valid, red_warps}), {31'h0, 1'b1, 32'h30});
    @(negedge clk); red_ready = 1'b1;
    step();
    check("R7 bcast taken", 64'({red_valid, bar_ready}), 64'h1);
  endtask

  task automatic t_error();
    ev(0, 0, 16, 0, 0);
    check("R9 bad id", 64'({error, rel_valid, blocked}), {31'h0, 1'b1, 1'b0, 32'h0});
    ev(0, 4, 4, 0, 0);
    check("R9 wrong cta", 64'({error, blocked}), {31'h0, 1'b1, 32'h0});
    ev(0, 0, 4, 3, 0);
    check("R9 bad kind", 64'({error, blocked}), {31'h0, 1'b1, 32'h0});
    step(); check("R9 error one cycle", 64'(error), 64'h0);
  endtask

  task automatic t_exit();
    ev(0, 0, 7, 0, 0);
    ev(0, 1, 7, 0, 0);
    ev(0, 2, 7, 0, 0); check("R8 held by warp3", 64'(blocked), 64'h7);
    @(negedge clk); exit_valid = 1'b1; exit_warp = 5'd3;
    step(); exit_valid = 1'b0;
    check("R8 sweep busy", 64'({bar_ready, exit_ready}), 64'h0);
    begin
      logic early = 1'b0;
      for (int i = 0; i < 7; i++) begin step(); if (rel_valid) early = 1'b1; end
      check("R8 no early sweep release", 64'(early), 64'h0);
    end
    step();
    check("R8 sweep release", 64'({rel_valid, rel_cta, rel_id}), {57'h0, 1'b1, 3'd0, 4'd7});
    check("R8 sweep mask", 64'({rel_warps, blocked}), {32'h7, 32'h0});
    for (int i = 0; i < 7; i++) step();
    check("R8 still sweeping", 64'(bar_ready), 64'h0);
    step();
    check("R8 sweep done", 64'({bar_ready, exit_ready}), 64'h3);
    ev(0, 3, 0, 0, 0); check("R8 exited warp rejected", 64'({error, blocked}), {31'h0, 1'b1, 32'h0});
  endtask

  task automatic t_launch();
    launch(3, 1);
    ev(1, 3, 9, 0, 0);
    check("R10 relaunched in cta1", 64'({error, rel_valid, blocked}), {30'h0, 2'b00, 32'h8});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    for (int w = 0; w < 4; w++) launch(w, 0);
    launch(4, 1);
    launch(5, 1);
    t_sync_all();
    t_arrive();
    t_counted();
    t_reduce();
    t_error();
    t_exit();
    t_launch();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule